// File: doc/BRIEF.md
# BCD Watchdog Countdown Timer

This block is a software watchdog with a time-out held as four packed BCD digits, from 00.01 to 99.99 seconds. Software programs the time-out through two byte-wide registers. Software then proves it is alive by touching either register at regular intervals. Every access restarts the countdown, and a read counts as an access as well as a write. Every access also clears any pending indication.

An external tick-enable input gives the hundredths-of-a-second time base. The internal counter steps down by one hundredth on each tick, with a decimal borrow. When the counter reaches zero, the block emits a one-cycle alarm event and sets a sticky flag. The counter then reloads at once, so the alarm keeps repeating while software stays silent. A stored time-out of zero turns the watchdog off.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset both registers read 0x00, `alarm_o` and `flag_o` are 0, and the watchdog is disabled.
- R2: Address 0 holds hundredths in bits 3:0 and tenths in bits 7:4. Address 1 holds seconds in bits 3:0 and tens of seconds in bits 7:4. A write (`acc_i`=1, `we_i`=1) stores `wdata_i` unchanged, including non-BCD nibbles. `rdata_o` always shows the stored byte at `addr_i`, and registers may be written in either order.
- R3: Any access, read or write, to either register reloads the countdown from the stored value, including the byte being written. In the next cycle `flag_o` and `alarm_o` are 0.
- R4: Each `tick_i` cycle without an access decrements the count by one hundredth with BCD borrow across all digits. With a stored value of N (decimal hundredths), `alarm_o` is 1 in the cycle after the N-th tick following a reload, and 0 after every other tick.
- R5: `alarm_o` is a one-cycle pulse that only follows a tick. `flag_o` sets together with it and stays 1 until the next access.
- R6: When the count reaches zero it reloads from the stored value, so with no access an alarm recurs every N ticks.
- R7: While both registers hold 0x00, no tick ever produces an alarm.
- R8: The countdown treats any stored nibble above 9 as 9. For example, a low byte of 0x0A counts like 0x09, and 0xF0 counts like 0x90.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read (with acc_i) |
| addr_i | input | 1 | Register select: 0 = fractional byte, 1 = seconds byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Stored byte at addr_i |
| tick_i | input | 1 | Hundredths-of-a-second tick enable |
| alarm_o | output | 1 | One-cycle alarm event |
| flag_o | output | 1 | Sticky watchdog flag |

## Verification
A table of time-outs is counted down to the alarm, one tick at a time. The table holds single-digit values, values that force a borrow across one, two and three digit boundaries, a mixed four-digit value and non-BCD nibbles. Each entry shows whether the alarm lands on exactly the expected tick or one tick off, which separates a correct borrow chain from a binary or truncated decrement. Directed tests cover the following:
- a read-only kick in the middle of a countdown
- free-running repetition
- the flag holding between accesses
- registers written in reverse order
- the disabled zero state

// File: rtl/bcd_wd_pkg.sv
package bcd_wd_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic digit_t digit_clamp(digit_t d);
    return (d > digit_t'(9)) ? digit_t'(9) : d;
  endfunction
endpackage

// File: rtl/bcd_wd_regs.sv
module bcd_wd_regs #(
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 2,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int TOT_W   = REG_W * NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [TOT_W-1:0]  stored_o,
  output logic [TOT_W-1:0]  next_o
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_i && (addr_i == ADDR_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wdata_i;
    end
    assign stored_o[g*REG_W +: REG_W] = regs_q[g];
    // value including a write landing this cycle, used for reload
    assign next_o[g*REG_W +: REG_W]   = hit ? wdata_i : regs_q[g];
  end

  assign rdata_o = regs_q[addr_i];
endmodule

// File: rtl/bcd_digit_dec.sv
module bcd_digit_dec
  import bcd_wd_pkg::*;
(
  input  digit_t d_i,
  input  logic   borrow_i,
  output digit_t d_o,
  output logic   borrow_o
);
  always_comb begin
    borrow_o = borrow_i && (d_i == '0);
    if (!borrow_i)        d_o = d_i;
    else if (d_i == '0)   d_o = digit_t'(9);
    else                  d_o = d_i - digit_t'(1);
  end
endmodule

// File: rtl/bcd_wd_counter.sv
module bcd_wd_counter
  import bcd_wd_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  localparam int CNT_W     = NUM_DIGITS * DIGIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  input  logic             enable_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec, load_clamp, reload_clamp;
  logic [NUM_DIGITS:0] borrow;
  logic at_end;

  assign borrow[0] = 1'b1;
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    bcd_digit_dec u_dec (
      .d_i     (cnt_q[g*DIGIT_W +: DIGIT_W]),
      .borrow_i(borrow[g]),
      .d_o     (cnt_dec[g*DIGIT_W +: DIGIT_W]),
      .borrow_o(borrow[g+1])
    );
    assign load_clamp[g*DIGIT_W +: DIGIT_W]   = digit_clamp(load_val_i[g*DIGIT_W +: DIGIT_W]);
    assign reload_clamp[g*DIGIT_W +: DIGIT_W] = digit_clamp(reload_val_i[g*DIGIT_W +: DIGIT_W]);
  end

  // count of one (or zero) reaches zero on this tick
  assign at_end   = (cnt_q[CNT_W-1:1] == '0);
  assign expire_o = tick_i && enable_i && !load_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_clamp;
    else if (tick_i && enable_i)   cnt_q <= at_end ? reload_clamp : cnt_dec;
  end
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog
  import bcd_wd_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int REG_W      = 8,
  localparam int CNT_W     = NUM_DIGITS * DIGIT_W,
  localparam int NUM_REGS  = CNT_W / REG_W,
  localparam int ADDR_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tick_i,
  output logic              alarm_o,
  output logic              flag_o
);
  logic [CNT_W-1:0] stored, stored_next;
  logic expire, alarm_q, flag_q;

  bcd_wd_regs #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (acc_i && we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .stored_o(stored),
    .next_o  (stored_next)
  );

  bcd_wd_counter #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (acc_i),
    .load_val_i  (stored_next),
    .reload_val_i(stored),
    .tick_i      (tick_i),
    .enable_i    (stored != '0),
    .expire_o    (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      alarm_q <= expire;
      if (acc_i)       flag_q <= 1'b0;
      else if (expire) flag_q <= 1'b1;
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;
endmodule

// File: rtl/bcd_watchdog_chk.sv
module bcd_watchdog_chk #(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 1,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              tick_i,
  input logic              alarm_o,
  input logic              flag_o,
  input logic [CNT_W-1:0]  stored_i
);
  assert_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && we_i) |=> stored_i[$past(addr_i)*REG_W +: REG_W] == $past(wdata_i));

  assert_access_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> (!flag_o && !alarm_o));

  assert_alarm_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i || acc_i) |=> !alarm_o);

  assert_alarm_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> flag_o);

  assert_flag_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> alarm_o);

  assert_disabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stored_i == '0) |=> !alarm_o);
endmodule

bind bcd_watchdog bcd_watchdog_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .acc_i   (acc_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick_i  (tick_i),
  .alarm_o (alarm_o),
  .flag_o  (flag_o),
  .stored_i(stored)
);

// File: tb/bcd_watchdog_test.sv
module bcd_watchdog_test;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic acc_i = 1'b0, we_i = 1'b0, tick_i = 1'b0;
  logic [0:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic alarm_o, flag_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bcd_watchdog uut (.*);

  // [31:24] byte 0, [23:16] byte 1, [15:0] expected ticks to alarm
  localparam logic [31:0] VEC [10] = '{
    {8'h01, 8'h00, 16'd1},    {8'h09, 8'h00, 16'd9},
    {8'h10, 8'h00, 16'd10},   {8'h00, 8'h01, 16'd100},
    {8'h05, 8'h01, 16'd105},  {8'h00, 8'h10, 16'd1000},
    {8'h0A, 8'h00, 16'd9},    {8'hF0, 8'h00, 16'd90},
    {8'h34, 8'h12, 16'd1234}, {8'h99, 8'h00, 16'd99}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i); acc_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); acc_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk_i); acc_i = 1; we_i = 0; addr_i = a; #1 d = rdata_o;
    @(negedge clk_i); acc_i = 0;
  endtask

  task automatic tick(output logic al);
    @(negedge clk_i); tick_i = 1;
    @(negedge clk_i); tick_i = 0; al = alarm_o;
  endtask

  // ticks until alarm (max limit), 0 if none
  task automatic run_to_alarm(input int lim, output int n);
    logic al;
    n = 0;
    for (int t = 1; t <= lim; t++) begin
      tick(al);
      if (al) begin n = t; return; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic al;
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    #1 check(rdata_o, 0, "R1 rdata addr0");
    check({alarm_o, flag_o}, 0, "R1 alarm/flag");
    rst_ni = 1;
    addr_i = 1; #1 check(rdata_o, 0, "R1 rdata addr1");
    run_to_alarm(30, n);
    check(n, 0, "R1/R7 disabled after reset");

    for (int v = 0; v < 10; v++) begin
      wr(0, VEC[v][31:24]);
      wr(1, VEC[v][23:16]);
      rd(0, d); check(d, VEC[v][31:24], "R2 readback byte0");
      rd(1, d); check(d, VEC[v][23:16], "R2 readback byte1");
      run_to_alarm(int'(VEC[v][15:0]) + 2, n);
      check(n, VEC[v][15:0], "R4/R8 ticks to alarm");
      check(flag_o, 1, "R5 flag set");
    end

    // R5 pulse width and flag hold
    wr(0, 8'h03); wr(1, 8'h00);
    run_to_alarm(5, n);
    @(negedge clk_i); check(alarm_o, 0, "R5 alarm one cycle");
    repeat (5) @(negedge clk_i);
    check(flag_o, 1, "R5 flag held");
    // R6 repetition
    run_to_alarm(10, n); check(n, 3, "R6 repeat period");
    run_to_alarm(10, n); check(n, 3, "R6 repeat again");
    // R3 read kick clears flag and restarts
    rd(1, d);
    check({alarm_o, flag_o}, 0, "R3 read clears flag");
    tick(al); tick(al);
    rd(0, d);
    run_to_alarm(10, n); check(n, 3, "R3 read reloads");
    // R3 write mid-count reloads with new value
    tick(al);
    wr(0, 8'h05);
    check(flag_o, 0, "R3 write clears flag");
    run_to_alarm(10, n); check(n, 5, "R3 write reloads");
    // R2 reverse order write
    wr(1, 8'h02); wr(0, 8'h07);
    rd(1, d); check(d, 8'h02, "R2 reverse order byte1");
    run_to_alarm(300, n); check(n, 207, "R2/R4 reverse order count");
    // R7 disabled by zeros
    wr(1, 8'h00); wr(0, 8'h00);
    run_to_alarm(200, n); check(n, 0, "R7 zero disables");
    check(flag_o, 0, "R7 no flag");
    // R8 both upper digits non-BCD -> 9900
    wr(1, 8'hFF); wr(0, 8'h00);
    rd(1, d); check(d, 8'hFF, "R2/R8 non-BCD stored");
    run_to_alarm(10000, n); check(n, 9900, "R8 clamp upper digits");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule